// File: doc/BRIEF.md
# USB OUT Endpoint Receiver with Prime and Enable Control

This block takes host-to-device data packets for up to 16 OUT endpoints and stores their payload in a 512-byte receive FIFO that the CPU drains one byte at a time. The device side is a simple token and byte interface. A token strobe carries the endpoint number and the data-toggle bit of the packet that follows. A byte stream then brings the payload, ending with a last strobe that carries the CRC result. For each packet whose CRC is good, the block returns one handshake choice: ACK, NAK or STALL.

Software decides which endpoints may take data by setting their prime bits. Any number of endpoints can be primed at once. A single global enable bit opens reception for all of them together. The enable clears itself after one packet has been captured. The prime bits stay set, except for endpoint 0, which loses its prime after every capture. This gives software a fixed order between a control transfer's stages. Stall and data-toggle state are also kept per endpoint. A bus reset returns all of this state to idle.

A packet that fails its CRC, or whose toggle is not the one expected, leaves no bytes in the FIFO. The FIFO keeps a committed write pointer next to a working one, so a partial packet can be rolled back.

Top module: `usb_out_rx`

## Requirements
- R1: Handshake encoding is 1 = ACK, 2 = NAK, 3 = STALL. It appears on `hsCode` with `hsValid` high for exactly one cycle, in the cycle after `rxLast` when the CRC is good. The choice is made when the token arrives, in this order: STALL if the endpoint is stalled; otherwise NAK if the endpoint is not primed or enable is clear; otherwise ACK.
- R2: Writing 1 to the enable register (address 1, bit 0) opens reception. Enable clears itself when a packet is captured, so a second packet without a fresh enable write gets NAK.
- R3: Writing the prime register (address 2, bit 0) sets or clears the prime bit of the selected endpoint. Prime bits survive a capture on every endpoint except endpoint 0, whose prime is cleared by its own capture.
- R4: Writing the stall register (address 3, bit 0) sets or clears stall on the endpoint selected in register address 0. Stall stays with that endpoint after the selection changes.
- R5: The status register (address 5) reads as follows: bits [3:0] hold the endpoint of the last captured packet, bit 8 is 1 when the FIFO holds data, and bit 9 is the expected toggle of the selected endpoint. After reset it reads 0.
- R6: The data register (address 7) shows the oldest unread byte in bits [7:0]. A read strobe at that address advances to the next byte. Bytes come out in arrival order.
- R7: Writing 1 to the flush register (address 6, bit 0) empties the FIFO.
- R8: A capture sets the event-pending bit (address 9, bit 0). Writing 1 to that bit clears it. `irq` is high while the pending bit and the event-enable bit (address 8, bit 0) are both set.
- R9: Each endpoint has an expected toggle bit. A write to the toggle register (address 4, bit 0) sets it for the selected endpoint, and each capture flips it. A packet with the wrong toggle on an ACK path is still ACKed, but its data is discarded, no event is raised, and enable stays set.
- R10: A packet with a CRC failure gets no handshake, leaves no data, and leaves enable, prime and toggle state unchanged.
- R11: A `busReset` pulse clears all prime, stall and toggle bits and the enable bit, and empties the FIFO.
- R12: The FIFO holds 512 bytes. A full 512-byte packet is kept whole, and bytes beyond that capacity are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tokValid | input | 1 | OUT token strobe |
| tokEp | input | 4 | Token endpoint number |
| tokPid | input | 1 | Data toggle of the coming packet (0 = DATA0, 1 = DATA1) |
| rxValid | input | 1 | Received byte strobe |
| rxByte | input | 8 | Received byte |
| rxLast | input | 1 | End of packet; may coincide with the last byte or stand alone for an empty packet |
| rxCrcOk | input | 1 | CRC result, sampled with rxLast |
| busReset | input | 1 | Bus reset pulse |
| regWe | input | 1 | CPU register write strobe |
| regRe | input | 1 | CPU register read strobe (advances the FIFO at the data address) |
| regAddr | input | 4 | CPU register address |
| regWdata | input | 8 | CPU write data |
| regRdata | output | 16 | CPU read data for regAddr (combinational) |
| hsValid | output | 1 | Handshake strobe |
| hsCode | output | 2 | Handshake choice |
| irq | output | 1 | Receive interrupt |

## Verification
Several properties are checked on every cycle. Enable falls after each capture, and endpoint 0 loses its prime. A CRC failure never yields a handshake. A flush or bus reset leaves the FIFO empty with all endpoint state clear. Stored data never exceeds the FIFO depth. Only the bench's scenarios can show the rest: the handshake priority against stall, prime and enable, byte order through the FIFO, the discarding of mismatched-toggle and bad-CRC payloads, and the persistence of stall and prime across selection changes. These are compared against a reference model kept in the bench.

// File: rtl/usb_out_rx_pkg.sv
`timescale 1ns/1ps
package usb_out_rx_pkg;
  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_e;

  // strobes from the endpoint control to the FIFO datapath
  typedef struct packed {
    logic push;
    logic commit;
    logic rollback;
    logic flush;
    logic pop;
  } fifo_ctl_t;

  localparam logic [3:0] A_EPSEL  = 4'd0;
  localparam logic [3:0] A_ENABLE = 4'd1;
  localparam logic [3:0] A_PRIME  = 4'd2;
  localparam logic [3:0] A_STALL  = 4'd3;
  localparam logic [3:0] A_TOGGLE = 4'd4;
  localparam logic [3:0] A_STATUS = 4'd5;
  localparam logic [3:0] A_FLUSH  = 4'd6;
  localparam logic [3:0] A_DATA   = 4'd7;
  localparam logic [3:0] A_EVEN   = 4'd8;
  localparam logic [3:0] A_EVPEND = 4'd9;
endpackage

// File: rtl/usb_out_rx_fifo.sv
`timescale 1ns/1ps
module usb_out_rx_fifo
  import usb_out_rx_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic      clk,
  input  logic      rst_n,
  input  fifo_ctl_t ctl,
  input  logic [7:0] wrByte,
  output logic [7:0] rdByte,
  output logic      have
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wPtr, cPtr, rPtr;
  logic          full, doWrite;

  assign full    = (wPtr - rPtr) == DEPTH_P;
  assign doWrite = ctl.push && !full;
  assign have    = cPtr != rPtr;
  assign rdByte  = mem[rPtr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (doWrite) mem[wPtr[AW-1:0]] <= wrByte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ctl.flush) begin
      wPtr <= '0;
      cPtr <= '0;
      rPtr <= '0;
    end else begin
      if (ctl.rollback)   wPtr <= cPtr;
      else if (doWrite)   wPtr <= wPtr + PW'(1);
      if (ctl.commit)     cPtr <= wPtr + PW'(doWrite);
      if (ctl.pop && have) rPtr <= rPtr + PW'(1);
    end
  end

  // R12: stored bytes never exceed capacity
  assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wPtr - rPtr) <= DEPTH_P);
  // R7: a flush leaves nothing readable
  assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.flush |=> !have);
  // R6: committed data never runs ahead of the working pointer
  assert_commit_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cPtr - rPtr) <= (wPtr - rPtr));
endmodule

// File: rtl/usb_out_rx_ctrl.sv
`timescale 1ns/1ps
module usb_out_rx_ctrl
  import usb_out_rx_pkg::*;
#(
  parameter int NUM_EP = 16,
  parameter int EP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tokValid,
  input  logic [EP_W-1:0]   tokEp,
  input  logic              tokPid,
  input  logic              rxValid,
  input  logic              rxLast,
  input  logic              rxCrcOk,
  input  logic              busReset,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [3:0]        regAddr,
  input  logic [7:0]        regWdata,
  input  logic              fifoHave,
  output fifo_ctl_t         fifoCtl,
  output logic              hsValid,
  output logic [1:0]        hsCode,
  output logic [EP_W-1:0]   epSel,
  output logic [EP_W-1:0]   rxEp,
  output logic              enable,
  output logic [NUM_EP-1:0] toggle,
  output logic              evEnable,
  output logic              evPending,
  output logic              irq
);
  logic [NUM_EP-1:0] prime, stall;
  logic              inPkt, pktAccept;
  logic [EP_W-1:0]   pktEp;
  logic [1:0]        pktCode, tokCode;
  logic              endEvt, goodEnd, commit;

  always_comb begin
    if (stall[tokEp])                    tokCode = HS_STALL;
    else if (prime[tokEp] && enable)     tokCode = HS_ACK;
    else                                 tokCode = HS_NAK;
  end

  assign endEvt  = inPkt && rxLast;
  assign goodEnd = endEvt && rxCrcOk;
  assign commit  = goodEnd && pktAccept;

  assign fifoCtl.push     = inPkt && pktAccept && rxValid;
  assign fifoCtl.commit   = commit;
  assign fifoCtl.rollback = endEvt && !commit;
  assign fifoCtl.flush    = busReset || (regWe && regAddr == A_FLUSH && regWdata[0]);
  assign fifoCtl.pop      = regRe && regAddr == A_DATA && fifoHave;
  assign irq              = evPending && evEnable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prime <= '0; stall <= '0; toggle <= '0; enable <= 1'b0;
      inPkt <= 1'b0; pktAccept <= 1'b0; pktEp <= '0; pktCode <= HS_NONE;
      hsValid <= 1'b0; hsCode <= HS_NONE; epSel <= '0; rxEp <= '0;
      evEnable <= 1'b0; evPending <= 1'b0;
    end else begin
      hsValid <= goodEnd && !busReset;
      hsCode  <= goodEnd ? pktCode : HS_NONE;
      if (regWe && regAddr == A_EVEN) evEnable <= regWdata[0];
      if (commit && !busReset) evPending <= 1'b1;
      else if (regWe && regAddr == A_EVPEND && regWdata[0]) evPending <= 1'b0;
      if (busReset) begin
        prime <= '0; stall <= '0; toggle <= '0; enable <= 1'b0; inPkt <= 1'b0;
      end else begin
        if (regWe) begin
          case (regAddr)
            A_EPSEL:  epSel         <= regWdata[EP_W-1:0];
            A_ENABLE: enable        <= regWdata[0];
            A_PRIME:  prime[epSel]  <= regWdata[0];
            A_STALL:  stall[epSel]  <= regWdata[0];
            A_TOGGLE: toggle[epSel] <= regWdata[0];
            default: ;
          endcase
        end
        if (tokValid) begin
          inPkt     <= 1'b1;
          pktEp     <= tokEp;
          pktCode   <= tokCode;
          pktAccept <= (tokCode == HS_ACK) && (tokPid == toggle[tokEp]);
        end else if (endEvt) begin
          inPkt <= 1'b0;
        end
        if (commit) begin
          enable        <= 1'b0;
          toggle[pktEp] <= ~toggle[pktEp];
          rxEp          <= pktEp;
          if (pktEp == '0) prime[0] <= 1'b0;
        end
      end
    end
  end

  // R2: one capture per enable
  assert_enable_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifoCtl.commit |=> !enable);
  // R3: endpoint 0 loses its prime after a capture
  assert_ep0_unprime_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifoCtl.commit && pktEp == '0) |=> !prime[0]);
  // R10: CRC failure yields no handshake
  assert_crc_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inPkt && rxLast && !rxCrcOk) |=> !hsValid);
  // R11: bus reset clears endpoint state
  assert_bus_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busReset |=> (prime == '0 && stall == '0 && toggle == '0 && !enable));
  // R1: a handshake always carries a real code
  assert_hs_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hsValid |-> hsCode != HS_NONE);
endmodule

// File: rtl/usb_out_rx.sv
`timescale 1ns/1ps
module usb_out_rx
  import usb_out_rx_pkg::*;
#(
  parameter int NUM_EP     = 16,
  parameter int FIFO_DEPTH = 512,
  localparam int EP_W      = $clog2(NUM_EP)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tokValid,
  input  logic [EP_W-1:0] tokEp,
  input  logic            tokPid,
  input  logic            rxValid,
  input  logic [7:0]      rxByte,
  input  logic            rxLast,
  input  logic            rxCrcOk,
  input  logic            busReset,
  input  logic            regWe,
  input  logic            regRe,
  input  logic [3:0]      regAddr,
  input  logic [7:0]      regWdata,
  output logic [15:0]     regRdata,
  output logic            hsValid,
  output logic [1:0]      hsCode,
  output logic            irq
);
  fifo_ctl_t         fifoCtl;
  logic              fifoHave, enable, evEnable, evPending;
  logic [7:0]        rdByte;
  logic [EP_W-1:0]   epSel, rxEp;
  logic [NUM_EP-1:0] toggle;

  usb_out_rx_ctrl #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tokValid(tokValid), .tokEp(tokEp), .tokPid(tokPid),
    .rxValid(rxValid), .rxLast(rxLast), .rxCrcOk(rxCrcOk), .busReset(busReset),
    .regWe(regWe), .regRe(regRe), .regAddr(regAddr), .regWdata(regWdata),
    .fifoHave(fifoHave), .fifoCtl(fifoCtl), .hsValid(hsValid), .hsCode(hsCode),
    .epSel(epSel), .rxEp(rxEp), .enable(enable), .toggle(toggle),
    .evEnable(evEnable), .evPending(evPending), .irq(irq)
  );

  usb_out_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .ctl(fifoCtl), .wrByte(rxByte),
    .rdByte(rdByte), .have(fifoHave)
  );

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_EPSEL:  regRdata[EP_W-1:0] = epSel;
      A_ENABLE: regRdata[0]        = enable;
      A_STATUS: begin
        regRdata[EP_W-1:0] = rxEp;
        regRdata[8]        = fifoHave;
        regRdata[9]        = toggle[epSel];
      end
      A_DATA:   regRdata[7:0]      = rdByte;
      A_EVEN:   regRdata[0]        = evEnable;
      A_EVPEND: regRdata[0]        = evPending;
      default:  regRdata           = '0;
    endcase
  end
endmodule

// File: tb/usb_out_rx_bench.sv
`timescale 1ns/1ps
module usb_out_rx_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tokValid = 0, tokPid = 0, rxValid = 0, rxLast = 0, rxCrcOk = 0, busReset = 0;
  logic regWe = 0, regRe = 0;
  logic [3:0] tokEp = 0, regAddr = 0;
  logic [7:0] rxByte = 0, regWdata = 0;
  logic [15:0] regRdata;
  logic hsValid, irq;
  logic [1:0] hsCode;

  usb_out_rx u_usb_out_rx (
    .clk(clk), .rst_n(rst_n), .tokValid(tokValid), .tokEp(tokEp), .tokPid(tokPid),
    .rxValid(rxValid), .rxByte(rxByte), .rxLast(rxLast), .rxCrcOk(rxCrcOk),
    .busReset(busReset), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .hsValid(hsValid), .hsCode(hsCode),
    .irq(irq)
  );

  always #2.5 clk = ~clk;

  int total = 0, fails = 0;
  bit mPrime[16], mStall[16], mTog[16];
  bit mEn = 0, mPend = 0, mEvEn = 0;
  int mSel = 0, mRxEp = 0;
  byte unsigned mQ[$];

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int expHs(input int ep);
    if (mStall[ep]) return 3;
    if (!mPrime[ep] || !mEn) return 2;
    return 1;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 0;
  endtask
  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk); regAddr = a; #1 v = regRdata;
  endtask

  task automatic selEp(input int e);  wr(4'd0, 8'(e)); mSel = e; endtask
  task automatic setEn(input bit v);  wr(4'd1, 8'(v)); mEn = v; endtask
  task automatic setPrime(input bit v); wr(4'd2, 8'(v)); mPrime[mSel] = v; endtask
  task automatic setStall(input bit v); wr(4'd3, 8'(v)); mStall[mSel] = v; endtask
  task automatic setTog(input bit v); wr(4'd4, 8'(v)); mTog[mSel] = v; endtask
  task automatic flushQ(); wr(4'd6, 8'd1); mQ.delete(); endtask
  task automatic clrPend(); wr(4'd9, 8'd1); mPend = 0; endtask
  task automatic pulseReset();
    @(negedge clk); busReset = 1;
    @(negedge clk); busReset = 0;
    for (int i = 0; i < 16; i++) begin mPrime[i] = 0; mStall[i] = 0; mTog[i] = 0; end
    mEn = 0; mQ.delete();
  endtask

  task automatic checkStatus(input string tag);
    logic [15:0] v;
    rd(4'd5, v);
    chk({tag, " R5 rxEp"}, int'(v[3:0]), mRxEp);
    chk({tag, " R5 have"}, int'(v[8]), int'(mQ.size() != 0));
    chk({tag, " R9 toggle"}, int'(v[9]), int'(mTog[mSel]));
    chk({tag, " R8 irq"}, int'(irq), int'(mPend && mEvEn));
  endtask

  task automatic drain(input string tag);
    logic [15:0] v;
    while (mQ.size() != 0) begin
      @(negedge clk); regAddr = 4'd7; #1 v = regRdata;
      chk({tag, " R6 data"}, int'(v[7:0]), int'(mQ.pop_front()));
      regRe = 1; @(negedge clk); regRe = 0;
    end
    checkStatus({tag, " drained"});
  endtask

  task automatic sendPkt(input string tag, input int ep, input bit pid, input int n,
                         input bit crc, input byte unsigned seed);
    int code;
    logic gotV; logic [1:0] gotC;
    code = expHs(ep);
    @(negedge clk); tokValid = 1; tokEp = 4'(ep); tokPid = pid;
    @(negedge clk); tokValid = 0;
    if (n == 0) begin
      rxLast = 1; rxCrcOk = crc;
      @(negedge clk);
    end else begin
      for (int i = 0; i < n; i++) begin
        rxValid = 1; rxByte = 8'(seed + i); rxLast = (i == n - 1); rxCrcOk = crc;
        @(negedge clk);
      end
    end
    rxValid = 0; rxLast = 0; rxCrcOk = 0;
    gotV = hsValid; gotC = hsCode;
    if (!crc) begin
      chk({tag, " R10 no handshake"}, int'(gotV), 0);
    end else begin
      chk({tag, " R1 hsValid"}, int'(gotV), 1);
      chk({tag, " R1 hsCode"}, int'(gotC), code);
      if (code == 1 && pid == mTog[ep]) begin
        for (int i = 0; i < n; i++) if (mQ.size() < 512) mQ.push_back(8'(seed + i));
        mEn = 0; mTog[ep] = ~mTog[ep]; mPend = 1; mRxEp = ep;
        if (ep == 0) mPrime[0] = 0;
      end
    end
    @(negedge clk);
    chk({tag, " R1 strobe single"}, int'(hsValid), 0);
  endtask

  initial begin
    #(5ns * 150000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'h5eed_0b1));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    rd(4'd5, v); chk("reset R5 status", int'(v), 0);
    chk("reset R1 hsValid", int'(hsValid), 0);
    chk("reset R8 irq", int'(irq), 0);

    // R8 event enable
    wr(4'd8, 8'd1); mEvEn = 1;
    // R1 priority: stall beats primed+enabled
    selEp(2); setPrime(1); setEn(1); setStall(1);
    sendPkt("stall prio", 2, 0, 3, 1, 8'h10);
    setStall(0);
    sendPkt("ack after unstall", 2, 0, 3, 1, 8'h20);
    checkStatus("after ep2");
    // R2 enable self clears -> NAK
    sendPkt("R2 second pkt nak", 2, 1, 2, 1, 8'h30);
    // NAK on unprimed endpoint
    setEn(1);
    sendPkt("R1 unprimed nak", 3, 0, 2, 1, 8'h40);
    drain("first");
    clrPend(); checkStatus("R8 cleared");
    // R3 prime persistence vs ep0
    selEp(0); setPrime(1); selEp(1); setPrime(1); setEn(1);
    sendPkt("R3 ep1 a", 1, 0, 4, 1, 8'h50);
    setEn(1);
    sendPkt("R3 ep1 again", 1, 1, 4, 1, 8'h60);
    setEn(1);
    sendPkt("R3 ep0 first", 0, 0, 8, 1, 8'h70);
    setEn(1);
    sendPkt("R3 ep0 unprimed nak", 0, 1, 8, 1, 8'h80);
    drain("R3");
    // R4 stall persists across selection
    selEp(5); setStall(1); selEp(6);
    sendPkt("R4 ep5 stall", 5, 0, 1, 1, 8'h90);
    // R9 toggle mismatch: ACK, discard, no event, enable stays
    clrPend(); setEn(1);
    sendPkt("R9 mismatch", 1, 1, 3, 1, 8'hA0);
    checkStatus("R9 after mismatch");
    rd(4'd1, v); chk("R9 enable kept", int'(v[0]), 1);
    // R10 CRC failure
    sendPkt("R10 crc bad", 1, 0, 5, 0, 8'hB0);
    rd(4'd1, v); chk("R10 enable kept", int'(v[0]), 1);
    checkStatus("R10 after");
    sendPkt("R10 recover", 1, 0, 0, 1, 8'hC0);
    // R9 toggle write
    selEp(1); setTog(1); checkStatus("R9 pid write");
    // R12 full 512 capture plus overflow
    setEn(1);
    sendPkt("R12 full", 1, 1, 514, 1, 8'h00);
    chk("R12 stored count", mQ.size(), 512);
    checkStatus("R12 after");
    drain("R12");
    // R7 flush
    setEn(1);
    sendPkt("R7 fill", 1, 0, 6, 1, 8'hD0);
    flushQ(); checkStatus("R7 flushed");
    // R11 bus reset
    selEp(3); setPrime(1); setStall(1); setTog(1); setEn(1);
    sendPkt("R11 prefill", 1, 1, 4, 1, 8'hE0);
    pulseReset();
    checkStatus("R11 after reset");
    setEn(1);
    sendPkt("R11 prime gone", 1, 0, 2, 1, 8'hF0);
    sendPkt("R11 stall gone", 3, 0, 2, 1, 8'hF8);

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom % 8;
      case (op)
        0: selEp($urandom % 4);
        1: setPrime($urandom % 4 != 0);
        2: setEn(1);
        3: setStall($urandom % 4 == 0);
        4: setTog($urandom % 2);
        5: drain("rand");
        default: begin
          int ep;
          bit pid;
          ep = $urandom % 4;
          pid = ($urandom % 4 == 0) ? ~mTog[ep] : mTog[ep];
          sendPkt("rand pkt", ep, pid, $urandom % 7, ($urandom % 8) != 0, 8'($urandom));
          checkStatus("rand");
          if (mPend && ($urandom % 2)) clrPend();
        end
      endcase
    end
    drain("final");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule